// File: doc/BRIEF.md
# Supply Monitor and Backup Sequencer

This block controls power-fail protection for a battery-backed static memory. Three digital comparator flags report the state of the main supply. One flag says the supply is above the full-function level. One says it is above the write-protect level. One says it is above the battery switchover level, which is the lowest of the three. The block synchronises each flag and debounces it. A small state machine then drives four controls: memory write inhibit, isolation of the memory's host bus (inputs ignored, outputs released to high impedance), selection of the backup battery, and a status bit that reports whether the factory shipping seal is still intact.

While the seal is intact, the battery stays disconnected whatever the supply does. This keeps the cell fresh until the part first sees a valid supply. After the seal is broken, the machine moves between full operation, write-protected operation and battery backup. Two thresholds set the hysteresis: protection starts when the supply drops below the protect level, and full operation returns only once the supply climbs above the higher full-function level. A synchronous reset restores the sealed state.

Top module: `pwrfail_sequencer`

## Requirements
- R1: During and after a synchronous reset, the outputs show the sealed state: sealed_o=1, wr_protect_o=1, bus_isolate_o=1, batt_sel_o=0.
- R2: The seal breaks only once the filtered protect flag (and so the switchover flag) is high. sealed_o then stays 0 until the next reset.
- R3: While sealed, a supply below the protect or switchover level keeps batt_sel_o=0, with write protect and bus isolation held high.
- R4: Full operation (wr_protect_o=0, bus_isolate_o=0, batt_sel_o=0) is entered only while the filtered full-function flag is high.
- R5: From full operation, a supply below the protect level sets wr_protect_o=1 and bus_isolate_o=1.
- R6: Hysteresis: with the supply between the protect and full-function levels, the block stays in full operation if it was there, and stays protected if it was protected.
- R7: After the seal is broken, a supply below the switchover level sets batt_sel_o=1. Write protect and bus isolation are always high whenever batt_sel_o is 1.
- R8: From backup, a supply back above the switchover level clears batt_sel_o. The block stays protected unless the full-function flag is also high, in which case it goes straight to full operation.
- R9: Each comparator flag passes through a two-stage synchroniser, then a filter that accepts a new level only after it has persisted for FILT_CYCLES consecutive clocks. A level applied before clock edge 1 changes the outputs after edge FILT_CYCLES+3. A pulse shorter than FILT_CYCLES clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_full_i | input | 1 | Supply above the full-function level (asynchronous) |
| cmp_prot_i | input | 1 | Supply above the write-protect level (asynchronous) |
| cmp_swap_i | input | 1 | Supply above the battery switchover level (asynchronous) |
| wr_protect_o | output | 1 | Inhibit memory writes |
| bus_isolate_o | output | 1 | Ignore memory bus inputs and tri-state its outputs |
| batt_sel_o | output | 1 | Connect the backup battery to the memory |
| sealed_o | output | 1 | Shipping seal still intact |

## Verification
The assertions assume the three comparator flags form a thermometer code. Because the thresholds are ordered, full implies protect and protect implies switchover. The state-machine properties therefore never consider a full flag without the protect flag. The stimulus keeps to this by driving only the four legal supply levels (none, switchover only, switchover plus protect, all three), and it always changes the three flags together. The sweep resets the block and then applies every sequence of three such levels. Each level is held well past the filter window before the outputs are compared with a model computed in the bench. Separate runs time the filter latency and check that short glitches are rejected.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;

    // comparator channel indices; thresholds ordered swap < prot < full
    localparam int unsigned CH_SWAP = 0;
    localparam int unsigned CH_PROT = 1;
    localparam int unsigned CH_FULL = 2;
    localparam int unsigned NUM_CH  = 3;

    typedef enum logic [1:0] {
        ST_SEALED    = 2'd0,
        ST_NORMAL    = 2'd1,
        ST_PROTECTED = 2'd2,
        ST_BACKUP    = 2'd3
    } pf_state_e;

    typedef struct packed {
        logic wr_protect;
        logic bus_isolate;
        logic batt_sel;
        logic sealed;
    } pf_ctrl_t;

    typedef struct packed {
        logic full;
        logic prot;
        logic swap;
    } pf_level_t;

    function automatic pf_ctrl_t decode_ctrl(input pf_state_e st);
        pf_ctrl_t c;
        c.wr_protect  = (st != ST_NORMAL);
        c.bus_isolate = (st != ST_NORMAL);
        c.batt_sel    = (st == ST_BACKUP);
        c.sealed      = (st == ST_SEALED);
        return c;
    endfunction

    function automatic pf_state_e next_state(input pf_state_e st, input pf_level_t lv);
        pf_state_e n;
        n = st;
        unique case (st)
            ST_SEALED: begin
                if (lv.prot) n = lv.full ? ST_NORMAL : ST_PROTECTED;
            end
            ST_NORMAL: begin
                if (!lv.swap)      n = ST_BACKUP;
                else if (!lv.prot) n = ST_PROTECTED;
            end
            ST_PROTECTED: begin
                if (lv.full)       n = ST_NORMAL;
                else if (!lv.swap) n = ST_BACKUP;
            end
            ST_BACKUP: begin
                if (lv.swap) n = lv.full ? ST_NORMAL : ST_PROTECTED;
            end
            default: n = ST_SEALED;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pwrfail_deglitch.sv
module pwrfail_deglitch #(
    parameter int unsigned FILT_CYCLES = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_lvl;
    logic [CW-1:0]          run_cnt;
    logic                   level_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            level_q <= 1'b0;
        end else if (sync_lvl != level_q) begin
            if (run_cnt == CNT_LAST) begin
                level_q <= sync_lvl;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + CW'(1);
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign level_o = level_q;

    // a filtered change must agree with the synchronised input it came from
    assert_filter_follows_sync_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_q) |-> ($past(sync_lvl) == level_q));

    // the filtered level never moves while the synchronised input agrees with it
    assert_filter_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl == level_q) |=> $stable(level_q));

endmodule

// File: rtl/pwrfail_flag_bank.sv
module pwrfail_flag_bank
    import pwrfail_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] raw_i,
    output pf_level_t         level_o
);
    logic [NUM_CH-1:0] filt;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwrfail_deglitch #(
            .FILT_CYCLES(FILT_CYCLES),
            .SYNC_STAGES(SYNC_STAGES)
        ) deglitch_i (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_i[ch]),
            .level_o(filt[ch])
        );
    end

    always_comb begin
        level_o.full = filt[CH_FULL];
        level_o.prot = filt[CH_PROT];
        level_o.swap = filt[CH_SWAP];
    end

endmodule

// File: rtl/pwrfail_fsm.sv
module pwrfail_fsm
    import pwrfail_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pf_level_t level_i,
    output pf_ctrl_t  ctrl_o
);
    pf_state_e state_q;
    pf_state_e state_d;

    always_comb state_d = next_state(state_q, level_i);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEALED;
        else     state_q <= state_d;
    end

    always_comb ctrl_o = decode_ctrl(state_q);

    assert_seal_needs_prot_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEALED && !level_i.prot) |=> (state_q == ST_SEALED));

    assert_seal_never_returns_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_SEALED) |=> (state_q != ST_SEALED));

    assert_sealed_no_battery_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEALED) |-> !ctrl_o.batt_sel);

    assert_normal_needs_full_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_NORMAL && !level_i.full) |=> (state_q != ST_NORMAL));

    assert_leave_normal_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && !level_i.prot) |=> ctrl_o.wr_protect && ctrl_o.bus_isolate);

    assert_hysteresis_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && level_i.prot) |=> (state_q == ST_NORMAL));

    assert_battery_protects_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_o.batt_sel |-> (ctrl_o.wr_protect && ctrl_o.bus_isolate));

    assert_backup_release_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BACKUP && level_i.swap) |=> !ctrl_o.batt_sel);

endmodule

// File: rtl/pwrfail_sequencer.sv
module pwrfail_sequencer
    import pwrfail_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_full_i,
    input  logic cmp_prot_i,
    input  logic cmp_swap_i,
    output logic wr_protect_o,
    output logic bus_isolate_o,
    output logic batt_sel_o,
    output logic sealed_o
);
    logic [NUM_CH-1:0] raw_flags;
    pf_level_t         level;
    pf_ctrl_t          ctrl;

    always_comb begin
        raw_flags          = '0;
        raw_flags[CH_FULL] = cmp_full_i;
        raw_flags[CH_PROT] = cmp_prot_i;
        raw_flags[CH_SWAP] = cmp_swap_i;
    end

    pwrfail_flag_bank #(
        .FILT_CYCLES(FILT_CYCLES),
        .SYNC_STAGES(SYNC_STAGES)
    ) flag_bank_i (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_flags),
        .level_o(level)
    );

    pwrfail_fsm fsm_i (
        .clk    (clk),
        .rst    (rst),
        .level_i(level),
        .ctrl_o (ctrl)
    );

    assign wr_protect_o  = ctrl.wr_protect;
    assign bus_isolate_o = ctrl.bus_isolate;
    assign batt_sel_o    = ctrl.batt_sel;
    assign sealed_o      = ctrl.sealed;

    assert_reset_sealed_R1: assert property (@(posedge clk)
        $past(rst) |-> (sealed_o && wr_protect_o && bus_isolate_o && !batt_sel_o));

endmodule

// File: tb/pwrfail_sequencer_tb.sv
`timescale 1ns/1ps
module pwrfail_sequencer_tb_top;

    localparam int FILT = 4;
    localparam int SEALED = 0, NORMAL = 1, PROT = 2, BACKUP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c_full = 1'b0, c_prot = 1'b0, c_swap = 1'b0;
    logic wp, iso, batt, seal;
    int   checks_run = 0;
    int   checks_failed = 0;

    always #2.5 clk = ~clk;

    pwrfail_sequencer #(.FILT_CYCLES(FILT), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst),
        .cmp_full_i(c_full), .cmp_prot_i(c_prot), .cmp_swap_i(c_swap),
        .wr_protect_o(wp), .bus_isolate_o(iso), .batt_sel_o(batt), .sealed_o(seal)
    );

    // supply level: 0 below switchover, 1 switchover only, 2 plus protect, 3 all
    task automatic set_level(input int lvl);
        c_swap = (lvl >= 1);
        c_prot = (lvl >= 2);
        c_full = (lvl >= 3);
    endtask

    function automatic int model_next(input int st, input int lvl);
        case (st)
            SEALED: return (lvl == 3) ? NORMAL : (lvl == 2) ? PROT : SEALED;
            NORMAL: return (lvl >= 2) ? NORMAL : (lvl == 1) ? PROT : BACKUP;
            default: return (lvl == 3) ? NORMAL : (lvl >= 1) ? PROT : BACKUP;
        endcase
    endfunction

    task automatic check_state(input int exp_st, input string req);
        logic [3:0] act, exp;
        act = {wp, iso, batt, seal};
        exp = {exp_st != NORMAL, exp_st != NORMAL, exp_st == BACKUP, exp_st == SEALED};
        checks_run++;
        if (act !== exp) begin
            checks_failed++;
            $display("FAIL %s: {wp,iso,batt,seal} actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        set_level(0);
        repeat (3) @(negedge clk);
        check_state(SEALED, "R1");
        rst = 1'b0;
        @(negedge clk);
        check_state(SEALED, "R1");
    endtask

    task automatic settle();
        repeat (FILT + 6) @(negedge clk);
    endtask

    function automatic string tag_for(input int prev, input int nxt, input int lvl);
        if (prev == SEALED) return (nxt == SEALED) ? "R3" : "R2";
        if (nxt == BACKUP) return "R7";
        if (prev == BACKUP) return "R8";
        if (lvl == 2) return "R6";
        if (nxt == NORMAL) return "R4";
        return "R5";
    endfunction

    initial begin
        #(200000 * 5);
        checks_run++;
        checks_failed++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_failed);
        $finish;
    end

    initial begin
        // sweep every three-step sequence of supply levels from a fresh reset
        for (int seq = 0; seq < 64; seq++) begin
            int st;
            do_reset();
            st = SEALED;
            for (int step = 0; step < 3; step++) begin
                int lvl, nst;
                lvl = (seq >> (2 * step)) & 3;
                set_level(lvl);
                settle();
                nst = model_next(st, lvl);
                check_state(nst, tag_for(st, nst, lvl));
                st = nst;
            end
        end

        // R9 latency: level set before edge 1 shows after edge FILT+3
        do_reset();
        set_level(3);
        repeat (FILT + 2) @(negedge clk);
        check_state(SEALED, "R9");
        @(negedge clk);
        check_state(NORMAL, "R9");

        // R9 glitch of FILT-1 clocks is rejected
        settle();
        set_level(0);
        repeat (FILT - 1) @(negedge clk);
        set_level(3);
        settle();
        check_state(NORMAL, "R9");

        // R9 pulse of exactly FILT clocks is accepted, then recovers (R4)
        set_level(1);
        repeat (FILT) @(negedge clk);
        set_level(3);
        repeat (3) @(negedge clk);
        check_state(PROT, "R9");
        settle();
        check_state(NORMAL, "R4");

        // R3 sealed unit rides through a long loss without the battery
        do_reset();
        set_level(1);
        settle();
        set_level(0);
        settle();
        check_state(SEALED, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_failed);
        $finish;
    end

endmodule